// File: doc/BRIEF.md
# Automatic Gain-Ranging Sample Controller

This block chooses the gain step of a programmable amplifier placed in front of an ADC. The aim is a recorded dynamic range wider than the converter gives alone. It inspects every signed sample that the converter delivers. A sample whose magnitude comes close to the clipping point makes it lower the gain by one step. A long enough run of small samples makes it raise the gain by one step. Each sample leaves the block together with the gain code under which it was converted, so a later stage can scale it back to a common unit.

Gain codes run from 0 (least amplification) to `NUM_STEPS-1` (most amplification). The code changes only on the clock edge that accepts a sample, which is the boundary between two conversions. It moves by at most one step at that edge and stops at both ends of the range. The downward threshold is a fixed fraction of full scale. The upward threshold is that fraction divided by the step ratio, less a margin. The gap between the two gives hysteresis, and a programmable run length sets how long the signal must stay quiet before the gain goes up.

Top module: `gain_ranger`

## Requirements
- R1: Whenever reset is active, `gain_sel` is `NUM_STEPS-1` and `out_valid` is 0.
- R2: A sample accepted at an edge (`samp_valid` high) appears one cycle later with `out_valid` high, `out_data` equal to the sample, and `out_gain` equal to the `gain_sel` value present while the sample was offered.
- R3: A loud sample has magnitude at or above HI = floor(2^(SAMPLE_W-1)·CLIP_PCT/100), which is 614 for SAMPLE_W=12 and CLIP_PCT=30. At a code above 0, it lowers `gain_sel` by exactly one at the accepting edge.
- R4: A loud sample at code 0 leaves `gain_sel` at 0. The code never wraps.
- R5: A quiet sample has magnitude below LO = floor(2^(SAMPLE_W-1)·(CLIP_PCT/STEP_RATIO − MARGIN_PCT)/100), which is 266 for the bench values. When `hold_len` quiet samples arrive in a row, `gain_sel` rises by one at the edge that accepts the last of them.
- R6: A mid sample (LO ≤ magnitude < HI) or a loud sample restarts the quiet run. A mid sample leaves the code unchanged.
- R7: At code `NUM_STEPS-1`, quiet samples never raise the code.
- R8: `gain_sel` changes only at edges where `samp_valid` is high, and by at most one step. Data offered with `samp_valid` low has no effect on any output.
- R9: A `hold_len` of 0 acts like 1: a single quiet sample raises the code.
- R10: The magnitude of a negative sample is its two's-complement absolute value. The most negative code counts as 2^(SAMPLE_W-1).
- R11: After a step up, the run count starts again from zero, so the next step up needs another full run of `hold_len` quiet samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_len | input | HOLD_W | Number of consecutive quiet samples needed for a step up |
| samp_valid | input | 1 | A converted sample is offered this cycle |
| samp_data | input | SAMPLE_W | Signed sample from the converter |
| gain_sel | output | CODE_W | Gain step driven to the amplifier |
| out_valid | output | 1 | Tagged sample available |
| out_data | output | SAMPLE_W | Sample being passed on |
| out_gain | output | CODE_W | Gain code under which `out_data` was converted |

## Verification
The bench builds the block with SAMPLE_W=12, NUM_STEPS=4, HOLD_W=4 and the default percentages. With these values the thresholds are 614 and 266, so both thresholds, the extreme codes −2048 and 2047, and both sides of each threshold can be driven with exact expected results. Four gain codes are enough to walk the code from the ceiling down to the floor and back up within a few dozen samples. A four-bit run length allows runs of 0, 1 and 3, which exercise the zero case, the restart after a mid or loud sample, and the restart after a step up.

// File: rtl/gr_pkg.sv
package gr_pkg;

    typedef enum logic [1:0] {
        ZONE_QUIET = 2'd0,
        ZONE_MID   = 2'd1,
        ZONE_LOUD  = 2'd2
    } zone_t;

    function automatic longint level_of(input int width, input int pct);
        longint full;
        full = longint'(1) << (width - 1);
        return (full * pct) / 100;
    endfunction

endpackage

// File: rtl/gr_mag_classify.sv
module gr_mag_classify
    import gr_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int CLIP_PCT   = 30,
    parameter int STEP_RATIO = 2,
    parameter int MARGIN_PCT = 2
) (
    input  logic signed [SAMPLE_W-1:0] data_in,
    output zone_t                      zone
);
    localparam int     LOW_PCT = CLIP_PCT / STEP_RATIO - MARGIN_PCT;
    localparam longint HI_L    = level_of(SAMPLE_W, CLIP_PCT);
    localparam longint LO_L    = level_of(SAMPLE_W, LOW_PCT);
    localparam logic [SAMPLE_W:0] HI_LVL = (SAMPLE_W+1)'(HI_L);
    localparam logic [SAMPLE_W:0] LO_LVL = (SAMPLE_W+1)'(LO_L);

    logic [SAMPLE_W:0] mag;

    always_comb begin
        if (data_in[SAMPLE_W-1])
            mag = (SAMPLE_W+1)'(~{data_in[SAMPLE_W-1], data_in}) + (SAMPLE_W+1)'(1);
        else
            mag = {1'b0, data_in};
    end

    always_comb begin
        if (mag >= HI_LVL)
            zone = ZONE_LOUD;
        else if (mag < LO_LVL)
            zone = ZONE_QUIET;
        else
            zone = ZONE_MID;
    end

    always_comb begin
        assert (LO_LVL < HI_LVL);
    end

endmodule

// File: rtl/gr_gain_fsm.sv
module gr_gain_fsm
    import gr_pkg::*;
#(
    parameter int NUM_STEPS = 4,
    parameter int HOLD_W    = 8,
    localparam int CODE_W   = (NUM_STEPS > 2) ? $clog2(NUM_STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_valid,
    input  zone_t             zone,
    input  logic [HOLD_W-1:0] hold_len,
    output logic [CODE_W-1:0] gain
);
    localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(NUM_STEPS - 1);
    localparam logic [HOLD_W-1:0] RUN_MAX  = {HOLD_W{1'b1}};

    typedef struct packed {
        logic [CODE_W-1:0] gain;
        logic [HOLD_W-1:0] run;
    } st_t;

    st_t st_d, st_q;
    logic [HOLD_W:0] run_plus;

    always_comb begin
        st_d     = st_q;
        run_plus = {1'b0, st_q.run} + (HOLD_W+1)'(1);
        if (samp_valid) begin
            unique case (zone)
                ZONE_LOUD: begin
                    st_d.run = '0;
                    if (st_q.gain != '0)
                        st_d.gain = st_q.gain - CODE_W'(1);
                end
                ZONE_QUIET: begin
                    if (st_q.gain != TOP_CODE && run_plus >= {1'b0, hold_len}) begin
                        st_d.gain = st_q.gain + CODE_W'(1);
                        st_d.run  = '0;
                    end else if (st_q.run != RUN_MAX) begin
                        st_d.run = run_plus[HOLD_W-1:0];
                    end
                end
                default: st_d.run = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gain <= TOP_CODE;
            st_q.run  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain = st_q.gain;

    // R8
    gain_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gain != $past(st_q.gain)) |-> $past(samp_valid));

    // R8
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gain != $past(st_q.gain)) |->
        ((st_q.gain == $past(st_q.gain) + CODE_W'(1)) || (st_q.gain == $past(st_q.gain) - CODE_W'(1))));

    // R3
    loud_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && zone == ZONE_LOUD && st_q.gain != '0) |=> (st_q.gain == $past(st_q.gain) - CODE_W'(1)));

    // R4
    floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && zone == ZONE_LOUD && st_q.gain == '0) |=> (st_q.gain == '0));

    // R6
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && zone != ZONE_QUIET) |=> (st_q.run == '0));

    // R7
    ceiling_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && zone == ZONE_QUIET && st_q.gain == TOP_CODE) |=> (st_q.gain == TOP_CODE));

endmodule

// File: rtl/gr_tag_reg.sv
module gr_tag_reg #(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                samp_valid,
    input  logic [SAMPLE_W-1:0] samp_data,
    input  logic [CODE_W-1:0]   gain_now,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic [CODE_W-1:0]   out_gain
);
    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] data;
        logic [CODE_W-1:0]   gain;
    } tag_t;

    tag_t tag_d, tag_q;

    always_comb begin
        tag_d       = tag_q;
        tag_d.valid = samp_valid;
        if (samp_valid) begin
            tag_d.data = samp_data;
            tag_d.gain = gain_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else begin
            tag_q <= tag_d;
        end
    end

    assign out_valid = tag_q.valid;
    assign out_data  = tag_q.data;
    assign out_gain  = tag_q.gain;

    // R2
    tag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |=> (out_valid && out_gain == $past(gain_now) && out_data == $past(samp_data)));

    // R2
    tag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |=> !out_valid);

endmodule

// File: rtl/gain_ranger.sv
module gain_ranger
    import gr_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int NUM_STEPS  = 4,
    parameter int HOLD_W     = 8,
    parameter int CLIP_PCT   = 30,
    parameter int STEP_RATIO = 2,
    parameter int MARGIN_PCT = 2,
    localparam int CODE_W    = (NUM_STEPS > 2) ? $clog2(NUM_STEPS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HOLD_W-1:0]   hold_len,
    input  logic                samp_valid,
    input  logic [SAMPLE_W-1:0] samp_data,
    output logic [CODE_W-1:0]   gain_sel,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic [CODE_W-1:0]   out_gain
);
    zone_t             zone;
    logic [CODE_W-1:0] gain_q;

    gr_mag_classify #(
        .SAMPLE_W  (SAMPLE_W),
        .CLIP_PCT  (CLIP_PCT),
        .STEP_RATIO(STEP_RATIO),
        .MARGIN_PCT(MARGIN_PCT)
    ) u_class (
        .data_in(samp_data),
        .zone   (zone)
    );

    gr_gain_fsm #(
        .NUM_STEPS(NUM_STEPS),
        .HOLD_W   (HOLD_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_valid(samp_valid),
        .zone      (zone),
        .hold_len  (hold_len),
        .gain      (gain_q)
    );

    gr_tag_reg #(
        .SAMPLE_W(SAMPLE_W),
        .CODE_W  (CODE_W)
    ) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_valid(samp_valid),
        .samp_data (samp_data),
        .gain_now  (gain_q),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_gain  (out_gain)
    );

    assign gain_sel = gain_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (gain_sel == CODE_W'(NUM_STEPS - 1) && !out_valid)));

endmodule

// File: tb/gain_ranger_test.sv
module gain_ranger_test;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 12;
    localparam int NS = 4;
    localparam int HW = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] hold_len = 4'd3;
    logic          samp_valid = 1'b0;
    logic [SW-1:0] samp_data = '0;
    logic [CW-1:0] gain_sel;
    logic          out_valid;
    logic [SW-1:0] out_data;
    logic [CW-1:0] out_gain;

    int n_checks = 0;
    int n_fails  = 0;
    int model_gain = NS - 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    gain_ranger #(
        .SAMPLE_W (SW),
        .NUM_STEPS(NS),
        .HOLD_W   (HW)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_len  (hold_len),
        .samp_valid(samp_valid),
        .samp_data (samp_data),
        .gain_sel  (gain_sel),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_gain  (out_gain)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input int s, input int exp_after, input string req);
        int tag_exp;
        @(negedge clk);
        tag_exp    = model_gain;
        samp_valid = 1'b1;
        samp_data  = SW'(s);
        @(negedge clk);
        samp_valid = 1'b0;
        chk({req, " R2 out_valid"}, int'(out_valid), 1);
        chk({req, " R2 out_data"}, int'($signed(out_data)), s);
        chk({req, " R2 out_gain"}, int'(out_gain), tag_exp);
        chk({req, " gain_sel"}, int'(gain_sel), exp_after);
        model_gain = exp_after;
    endtask

    task automatic t_reset();
        chk("R1 gain_sel in reset", int'(gain_sel), NS - 1);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 gain_sel after reset", int'(gain_sel), NS - 1);
    endtask

    task automatic t_loud();
        send(614, 2, "R3 at HI");
        send(-614, 1, "R10 negative at HI");
        send(-2048, 0, "R10 most negative");
        send(2047, 0, "R4 floor");
        send(613, 0, "R6 just below HI");
    endtask

    task automatic t_quiet();
        send(265, 0, "R5 run 1");
        send(0, 0, "R5 run 2");
        send(-265, 1, "R5 run 3 steps up");
        send(1, 1, "R11 new run 1");
        send(1, 1, "R11 new run 2");
        send(1, 2, "R11 new run 3");
    endtask

    task automatic t_restart();
        send(10, 2, "R6 quiet 1");
        send(10, 2, "R6 quiet 2");
        send(266, 2, "R6 mid at LO");
        send(10, 2, "R6 after mid 1");
        send(10, 2, "R6 after mid 2");
        send(10, 3, "R6 after mid 3");
        send(700, 2, "R3 from top");
        send(5, 2, "R6 quiet a");
        send(5, 2, "R6 quiet b");
        send(614, 1, "R6 loud breaks run");
        send(5, 1, "R6 after loud 1");
        send(5, 1, "R6 after loud 2");
        send(5, 2, "R6 after loud 3");
    endtask

    task automatic t_ceiling();
        send(5, 2, "R5 climb 1");
        send(5, 2, "R5 climb 2");
        send(5, 3, "R5 climb 3");
        for (int i = 0; i < 4; i++) send(5, 3, "R7 ceiling");
        send(1000, 2, "R3 leave ceiling");
    endtask

    task automatic t_idle();
        hold_len = 4'd1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            samp_data = (i % 2 == 0) ? SW'(2047) : SW'(0);
            @(negedge clk);
            chk("R8 no valid gain_sel", int'(gain_sel), 2);
            chk("R8 no valid out_valid", int'(out_valid), 0);
        end
    endtask

    task automatic t_zero_hold();
        hold_len = 4'd0;
        send(-1000, 1, "R3 before zero hold");
        send(3, 2, "R9 single quiet");
        send(-3, 3, "R9 second quiet");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_loud();
        t_quiet();
        t_restart();
        t_ceiling();
        t_idle();
        t_zero_hold();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule